// File: doc/BRIEF.md
# Mode-Selectable Dual/Single Address Decoder

This block decodes an address into one of eight output lines. It has two functions, and a mode input chooses between them. With the mode input low, it works as two independent 2-to-4 decoders. The lower group drives outputs 0 to 3 and the upper group drives outputs 4 to 7. With the mode input high, it works as one 3-to-8 decoder that covers all eight lines.

Each group has a pair of active-low enables. Three polarity inputs choose, for each group of four outputs, whether the selected line is driven high or driven low. In the 3-to-8 function, the two enable pairs are meant to be driven together. Each pair still gates its own group.

A parameter selects either purely combinational outputs or outputs captured on the rising clock edge. The registered form has a synchronous active-high reset and is the default.

Top module: `mode_decoder`

## Requirements
- R1: With `mode_i`=0, the lower group makes `dec_o[addr_a_i[1:0]]` the selected line among bits 3..0. The upper group makes `dec_o[4+addr_b_i]` the selected line among bits 7..4. Bit 2 of `addr_a_i` has no effect in this mode.
- R2: With `mode_i`=1, the line at index `addr_a_i` (0..7) is the only candidate for selection. `addr_b_i` has no effect in this mode. Address 0 selects bit 0 and address 7 selects bit 7.
- R3: The lower group decodes only when both bits of `en_lo_n_i` are 0. The upper group decodes only when both bits of `en_hi_n_i` are 0. A group that does not decode holds all four of its lines at the inactive level. With `mode_i`=1, a group also stays idle unless `addr_a_i[2]` selects it: 0 selects the lower group and 1 selects the upper group.
- R4: The active level of bits 3..0 is `pol_lo_i` XOR `pol_com_i`. The active level of bits 7..4 is `pol_hi_i` XOR `pol_com_i`. An active level of 1 means the selected line is high and the other lines are low. An active level of 0 means the reverse.
- R5: Within each group, at most one line differs from its inactive level. With `mode_i`=1, at most one line across all eight differs.
- R6: With `REG_OUT`=1, `dec_o` shows the decode of the inputs as they stood at the previous rising edge of `clk`.
- R7: With `REG_OUT`=1, a rising edge with `rst`=1 sets `dec_o` to all zeros, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | 0: two 2-to-4 decoders; 1: one 3-to-8 decoder |
| addr_a_i | input | 3 | Lower-group address; bit 2 is the high address bit in 3-to-8 use |
| addr_b_i | input | 2 | Upper-group address in dual use |
| en_lo_n_i | input | 2 | Active-low enable pair of the lower group |
| en_hi_n_i | input | 2 | Active-low enable pair of the upper group |
| pol_lo_i | input | 1 | Polarity select for bits 3..0 |
| pol_hi_i | input | 1 | Polarity select for bits 7..4 |
| pol_com_i | input | 1 | Common polarity select, XORed into both groups |
| dec_o | output | 8 | Decoded output lines |

## Verification
On every cycle, the assertions check the following:
- at most one raw select bit is set in each group, and at most one across both groups in 3-to-8 use;
- a disabled group settles to its inactive pattern;
- the register follows the combinational decode with one cycle of latency;
- reset clears the outputs.

The exact mapping of each address to its line can only be shown by the bench's sweep over every input combination in both modes, comparing against its own model. The same sweep shows that the ignored address bits have no effect and that the polarity inputs combine as described.

// File: rtl/dec_pkg.sv
package dec_pkg;

  // Active-low enable pair of one output group
  typedef logic [1:0] en_pair_t;

  // A group decodes only when both of its enable lines are low
  function automatic logic pair_enabled(en_pair_t en_n);
    return (en_n == 2'b00);
  endfunction

  // Inactive level of a line is the complement of the active level
  function automatic logic inactive_level(logic active_lvl);
    return ~active_lvl;
  endfunction

endpackage

// File: rtl/dec_onehot.sv
module dec_onehot #(
  parameter int SEL_W = 2,
  localparam int LINES = 1 << SEL_W
) (
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [LINES-1:0] hot_o
);

  for (genvar k = 0; k < LINES; k++) begin : g_line
    assign hot_o[k] = en_i && (sel_i == SEL_W'(k));
  end

endmodule

// File: rtl/dec_route.sv
module dec_route
  import dec_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             mode_i,
  input  logic [SEL_W:0]   addr_a_i,
  input  logic [SEL_W-1:0] addr_b_i,
  input  en_pair_t         en_lo_n_i,
  input  en_pair_t         en_hi_n_i,
  output logic             lo_en_o,
  output logic             hi_en_o,
  output logic [SEL_W-1:0] lo_sel_o,
  output logic [SEL_W-1:0] hi_sel_o
);

  logic lo_gate, hi_gate, top_bit;

  assign lo_gate = pair_enabled(en_lo_n_i);
  assign hi_gate = pair_enabled(en_hi_n_i);
  assign top_bit = addr_a_i[SEL_W];

  always_comb begin
    lo_sel_o = addr_a_i[SEL_W-1:0];
    if (mode_i) begin
      // 3-to-8 use: the top address bit picks which group may decode
      lo_en_o  = lo_gate && !top_bit;
      hi_en_o  = hi_gate && top_bit;
      hi_sel_o = addr_a_i[SEL_W-1:0];
    end else begin
      lo_en_o  = lo_gate;
      hi_en_o  = hi_gate;
      hi_sel_o = addr_b_i;
    end
  end

endmodule

// File: rtl/dec_polarity.sv
module dec_polarity
  import dec_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         lvl_sel_i,
  input  logic         lvl_com_i,
  input  logic [W-1:0] hot_i,
  output logic [W-1:0] line_o
);

  logic active_lvl;
  assign active_lvl = lvl_sel_i ^ lvl_com_i;

  // A selected line takes the active level; the rest take its complement
  for (genvar k = 0; k < W; k++) begin : g_bit
    assign line_o[k] = hot_i[k] ? active_lvl : inactive_level(active_lvl);
  end

endmodule

// File: rtl/dec_stage.sv
module dec_stage #(
  parameter int W          = 8,
  parameter bit REGISTERED = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  if (REGISTERED) begin : g_reg
    logic [W-1:0] q_r;
    always_ff @(posedge clk) begin
      if (rst) q_r <= '0;
      else     q_r <= d_i;
    end
    assign q_o = q_r;
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk = clk ^ rst;
    assign q_o = d_i;
  end

endmodule

// File: rtl/mode_decoder.sv
module mode_decoder
  import dec_pkg::*;
#(
  parameter int SEL_W   = 2,
  parameter bit REG_OUT = 1'b1,
  localparam int GRP_W  = 1 << SEL_W,
  localparam int OUT_W  = 2 * GRP_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_i,
  input  logic [SEL_W:0]   addr_a_i,
  input  logic [SEL_W-1:0] addr_b_i,
  input  logic [1:0]       en_lo_n_i,
  input  logic [1:0]       en_hi_n_i,
  input  logic             pol_lo_i,
  input  logic             pol_hi_i,
  input  logic             pol_com_i,
  output logic [OUT_W-1:0] dec_o
);

  logic             lo_en, hi_en;
  logic [SEL_W-1:0] lo_sel, hi_sel;
  logic [GRP_W-1:0] hot_lo, hot_hi;
  logic [GRP_W-1:0] line_lo, line_hi;
  logic [OUT_W-1:0] dec_comb;

  dec_route #(.SEL_W(SEL_W)) u_route (
    .mode_i    (mode_i),
    .addr_a_i  (addr_a_i),
    .addr_b_i  (addr_b_i),
    .en_lo_n_i (en_lo_n_i),
    .en_hi_n_i (en_hi_n_i),
    .lo_en_o   (lo_en),
    .hi_en_o   (hi_en),
    .lo_sel_o  (lo_sel),
    .hi_sel_o  (hi_sel)
  );

  dec_onehot #(.SEL_W(SEL_W)) u_hot_lo (.en_i(lo_en), .sel_i(lo_sel), .hot_o(hot_lo));
  dec_onehot #(.SEL_W(SEL_W)) u_hot_hi (.en_i(hi_en), .sel_i(hi_sel), .hot_o(hot_hi));

  dec_polarity #(.W(GRP_W)) u_pol_lo (
    .lvl_sel_i (pol_lo_i),
    .lvl_com_i (pol_com_i),
    .hot_i     (hot_lo),
    .line_o    (line_lo)
  );

  dec_polarity #(.W(GRP_W)) u_pol_hi (
    .lvl_sel_i (pol_hi_i),
    .lvl_com_i (pol_com_i),
    .hot_i     (hot_hi),
    .line_o    (line_hi)
  );

  assign dec_comb = {line_hi, line_lo};

  dec_stage #(.W(OUT_W), .REGISTERED(REG_OUT)) u_stage (
    .clk (clk),
    .rst (rst),
    .d_i (dec_comb),
    .q_o (dec_o)
  );

  // R5
  group_single_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hot_lo) && $onehot0(hot_hi));

  // R5
  wide_single_chk: assert property (@(posedge clk) disable iff (rst)
    mode_i |-> $onehot0({hot_hi, hot_lo}));

  if (REG_OUT) begin : g_reg_chk
    // R3
    lo_idle_chk: assert property (@(posedge clk) disable iff (rst)
      (en_lo_n_i != 2'b00) |=>
        dec_o[GRP_W-1:0] == {GRP_W{~$past(pol_lo_i ^ pol_com_i)}});

    // R3
    hi_idle_chk: assert property (@(posedge clk) disable iff (rst)
      (en_hi_n_i != 2'b00) |=>
        dec_o[OUT_W-1:GRP_W] == {GRP_W{~$past(pol_hi_i ^ pol_com_i)}});

    // R6
    latency_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> dec_o == $past(dec_comb));

    // R7
    reset_clear_chk: assert property (@(posedge clk)
      rst |=> dec_o == '0);
  end

endmodule

// File: tb/mode_decoder_tb.sv
module mode_decoder_tb;

  logic       clk = 1'b0;
  logic       rst;
  logic       mode_i;
  logic [2:0] addr_a_i;
  logic [1:0] addr_b_i;
  logic [1:0] en_lo_n_i;
  logic [1:0] en_hi_n_i;
  logic       pol_lo_i, pol_hi_i, pol_com_i;
  logic [7:0] dec_o;

  int compared   = 0;
  int mismatched = 0;
  bit done       = 1'b0;

  always #5 clk = ~clk;

  mode_decoder u_dut (
    .clk       (clk),
    .rst       (rst),
    .mode_i    (mode_i),
    .addr_a_i  (addr_a_i),
    .addr_b_i  (addr_b_i),
    .en_lo_n_i (en_lo_n_i),
    .en_hi_n_i (en_hi_n_i),
    .pol_lo_i  (pol_lo_i),
    .pol_hi_i  (pol_hi_i),
    .pol_com_i (pol_com_i),
    .dec_o     (dec_o)
  );

  // Behavioural model: position of the selected line, then level per bit
  function automatic logic [7:0] model(input logic [12:0] v);
    int lo_pick = -1;
    int hi_pick = -1;
    int a  = int'(v[11:9]);
    int b  = int'(v[8:7]);
    bit lo_ok = (v[6:5] == 2'b00);
    bit hi_ok = (v[4:3] == 2'b00);
    bit lvl_lo = v[2] ^ v[0];
    bit lvl_hi = v[1] ^ v[0];
    logic [7:0] r;
    if (v[12]) begin
      if (a < 4 && lo_ok)  lo_pick = a;
      if (a >= 4 && hi_ok) hi_pick = a;
    end else begin
      if (lo_ok) lo_pick = a % 4;
      if (hi_ok) hi_pick = 4 + b;
    end
    for (int k = 0; k < 8; k++) begin
      bit lvl = (k < 4) ? lvl_lo : lvl_hi;
      r[k] = (k == lo_pick || k == hi_pick) ? lvl : !lvl;
    end
    return r;
  endfunction

  task automatic apply(input logic [12:0] v);
    mode_i    = v[12];
    addr_a_i  = v[11:9];
    addr_b_i  = v[8:7];
    en_lo_n_i = v[6:5];
    en_hi_n_i = v[4:3];
    pol_lo_i  = v[2];
    pol_hi_i  = v[1];
    pol_com_i = v[0];
  endtask

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  // Lines that differ from the inactive level of their group
  function automatic int stray(input logic [7:0] z, input logic [12:0] v, input int grp);
    bit inact = (grp == 0) ? !(v[2] ^ v[0]) : !(v[1] ^ v[0]);
    int n = 0;
    for (int k = grp * 4; k < grp * 4 + 4; k++) if (z[k] != inact) n++;
    return n;
  endfunction

  initial begin
    logic [12:0] prev;
    string tag;
    rst = 1'b1;
    apply(13'h0000);
    repeat (2) @(posedge clk);

    // R7: reset wins over inputs that would otherwise drive ones
    @(negedge clk);
    apply(13'b0_000_00_11_11_111);
    @(negedge clk);
    check("R7 reset clear", dec_o, 8'h00);
    rst = 1'b0;

    prev = 13'h0;
    apply(prev);
    for (int i = 0; i < 8192; i++) begin
      @(negedge clk);
      apply(13'(i));
      prev = 13'(i);
      @(negedge clk);
      // R6: output sampled one edge after the inputs were applied
      tag = prev[12] ? "R2 R4 R6" : "R1 R4 R6";
      if (prev[6:5] != 2'b00 || prev[4:3] != 2'b00) tag = {tag, " R3"};
      check(tag, dec_o, model(prev));
      // R5
      compared++;
      if (stray(dec_o, prev, 0) > 1 || stray(dec_o, prev, 1) > 1 ||
          (prev[12] && stray(dec_o, prev, 0) + stray(dec_o, prev, 1) > 1)) begin
        mismatched++;
        $display("FAIL R5: got %b expected at most one active line", dec_o);
      end
    end

    // R2 edge addresses, active-high, both enable pairs low
    @(negedge clk);
    apply(13'b1_000_00_00_00_001);
    @(negedge clk);
    check("R2 address 0", dec_o, 8'b0000_0001);
    apply(13'b1_111_00_00_00_001);
    @(negedge clk);
    check("R2 address 7", dec_o, 8'b1000_0000);

    // R7: reset again in mid-run
    rst = 1'b1;
    @(negedge clk);
    check("R7 reset mid-run", dec_o, 8'h00);
    rst = 1'b0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(1_500_000ns);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule